// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder

This block sits on the write side of a byte-wide nonvolatile store and watches every bus write cycle (address plus data) for fixed multi-cycle unlock sequences. A three-write sequence switches global write protection on and, in the same stroke, opens a page-load window for the bytes that follow. A six-write sequence with a shared extended prefix either removes protection, starts a whole-array erase, or enters the identification read mode. A separate three-write sequence leaves identification mode and returns the part to normal reads.

The page buffer and the storage array are outside the block. The decoder grants a page-load window on `load_grant` and keeps it open until the page logic reports completion on `load_done`. While the window is open, every write is page data and is not decoded. A plain write that arrives while protection is on is rejected and starts a lockout period. During that period the decoder ignores all writes.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: After reset, `prot_on`, `id_mode`, `load_grant`, `erase_start` and `lockout` are all 0, and `id_rdata` is 00h.
- R2: Command addresses are matched on address bits 14:0 only, so bit 15 has no effect. A write whose low 15 bits differ from the expected 5555h or 2AAAh does not match.
- R3: The writes AAh to 5555h, 55h to 2AAAh and A0h to 5555h set `prot_on` to 1 and raise `load_grant`, both visible in the cycle after the third write.
- R4: While `load_grant` is 1, writes are page data and change neither `prot_on` nor `id_mode`. `load_grant` stays 1 until a cycle with `load_done` high, after which it is 0.
- R5: The six writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h clear `prot_on`.
- R6: The same six-write prefix ending with 10h@5555h drives `erase_start` high for exactly one cycle, the cycle after the sixth write.
- R7: The three-write prefix ending with 90h@5555h sets `id_mode`. In identification mode, `id_rdata` is BFh when `rd_addr` bits 14:0 equal 0, 5Dh when they equal 1, and 00h otherwise. Outside identification mode, `id_rdata` is 00h.
- R8: The three-write prefix ending with F0h@5555h clears `id_mode`.
- R9: The six-write prefix ending with 60h@5555h sets `id_mode`.
- R10: Any write that does not match the expected next address and data during a sequence returns the decoder to idle. That write is dropped, and it neither opens a window nor starts a lockout.
- R11: With protection off and the decoder idle, a plain write (anything other than AAh@5555h) raises `load_grant`.
- R12: With protection on and the decoder idle, a plain write leaves `load_grant` at 0 and raises `lockout` for exactly LOCK_CYCLES cycles. All writes during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One bus write cycle in this clock |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| load_done | input | 1 | Page logic closes the load window |
| rd_addr | input | ADDR_W | Read address for identification data |
| load_grant | output | 1 | Page-load window open; writes are page data |
| prot_on | output | 1 | Global write protection enabled |
| erase_start | output | 1 | One-cycle whole-array erase request |
| lockout | output | 1 | Rejected write penalty running; writes ignored |
| id_mode | output | 1 | Identification read mode active |
| id_rdata | output | DATA_W | Identification byte for `rd_addr` |

## Verification
A sequencer stuck in a wrong step shows up at the ports on the very next write. That write either fails to complete a command it should have completed, or it opens a page window or a lockout that should not exist. Either way, the flags are wrong one cycle after that write. A lockout counter that is miscounted shows up as a `lockout` high time that differs from LOCK_CYCLES. The bench therefore sweeps every data value in the final position of both the three-write and the six-write sequences, and it counts the exact lockout length.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

    localparam int CMP_W = 15;

    localparam logic [CMP_W-1:0] ADR_A = 15'h5555;
    localparam logic [CMP_W-1:0] ADR_B = 15'h2AAA;

    localparam logic [7:0] KEY1_CODE   = 8'hAA;
    localparam logic [7:0] KEY2_CODE   = 8'h55;
    localparam logic [7:0] PROG_CODE   = 8'hA0;
    localparam logic [7:0] EXT_CODE    = 8'h80;
    localparam logic [7:0] IDIN_CODE   = 8'h90;
    localparam logic [7:0] IDOUT_CODE  = 8'hF0;
    localparam logic [7:0] UNPROT_CODE = 8'h20;
    localparam logic [7:0] ERASE_CODE  = 8'h10;
    localparam logic [7:0] IDALT_CODE  = 8'h60;
    localparam logic [7:0] MAKER_BYTE  = 8'hBF;
    localparam logic [7:0] PART_BYTE   = 8'h5D;

    typedef enum logic [3:0] {
        CY_KEY1, CY_KEY2, CY_PROG, CY_EXT, CY_ID_IN,
        CY_ID_OUT, CY_UNPROT, CY_ERASE, CY_ID_ALT, CY_OTHER
    } cyc_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_K1, SQ_K2, SQ_X0, SQ_X1, SQ_X2
    } seq_e;

    typedef struct packed {
        seq_e seq;
        logic prot;
        logic id;
        logic grant;
        logic erase;
    } dec_st_t;

endpackage

// File: rtl/ulk_cycle_class.sv
module ulk_cycle_class
    import unlock_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output cyc_e              kind
);
    logic at_a;
    logic at_b;

    assign at_a = (addr[CMP_W-1:0] == ADR_A);
    assign at_b = (addr[CMP_W-1:0] == ADR_B);

    always_comb begin
        kind = CY_OTHER;
        if (at_b && data == DATA_W'(KEY2_CODE)) begin
            kind = CY_KEY2;
        end else if (at_a) begin
            if      (data == DATA_W'(KEY1_CODE))   kind = CY_KEY1;
            else if (data == DATA_W'(PROG_CODE))   kind = CY_PROG;
            else if (data == DATA_W'(EXT_CODE))    kind = CY_EXT;
            else if (data == DATA_W'(IDIN_CODE))   kind = CY_ID_IN;
            else if (data == DATA_W'(IDOUT_CODE))  kind = CY_ID_OUT;
            else if (data == DATA_W'(UNPROT_CODE)) kind = CY_UNPROT;
            else if (data == DATA_W'(ERASE_CODE))  kind = CY_ERASE;
            else if (data == DATA_W'(IDALT_CODE))  kind = CY_ID_ALT;
        end
    end
endmodule

// File: rtl/ulk_lock_timer.sv
module ulk_lock_timer #(
    parameter int LOCK_CYCLES = 37500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(LOCK_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R12: a started lockout is visible in the next cycle
    p_lock_starts_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/ulk_id_rom.sv
module ulk_id_rom
    import unlock_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              id_on,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (id_on) begin
            if (rd_addr[CMP_W-1:0] == CMP_W'(0))      rdata = DATA_W'(MAKER_BYTE);
            else if (rd_addr[CMP_W-1:0] == CMP_W'(1)) rdata = DATA_W'(PART_BYTE);
        end
    end
endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
    import unlock_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int LOCK_CYCLES = 37500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              load_grant,
    output logic              prot_on,
    output logic              erase_start,
    output logic              lockout,
    output logic              id_mode,
    output logic [DATA_W-1:0] id_rdata
);
    localparam dec_st_t RST_ST = '{seq: SQ_IDLE, prot: 1'b0, id: 1'b0,
                                   grant: 1'b0, erase: 1'b0};

    dec_st_t st_d;
    dec_st_t st_q;
    cyc_e    kind;
    logic    lock_start;
    logic    lock_busy;
    logic    take_wr;

    ulk_cycle_class #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) class_i (
        .addr (wr_addr),
        .data (wr_data),
        .kind (kind)
    );

    ulk_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (lock_start),
        .busy  (lock_busy)
    );

    ulk_id_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rom_i (
        .id_on   (st_q.id),
        .rd_addr (rd_addr),
        .rdata   (id_rdata)
    );

    assign take_wr = wr_valid && !lock_busy && !st_q.grant;

    always_comb begin
        st_d       = st_q;
        st_d.erase = 1'b0;
        lock_start = 1'b0;
        if (load_done && st_q.grant) begin
            st_d.grant = 1'b0;
        end
        if (take_wr) begin
            unique case (st_q.seq)
                SQ_IDLE: begin
                    if (kind == CY_KEY1)  st_d.seq   = SQ_K1;
                    else if (st_q.prot)   lock_start = 1'b1;
                    else                  st_d.grant = 1'b1;
                end
                SQ_K1: st_d.seq = (kind == CY_KEY2) ? SQ_K2 : SQ_IDLE;
                SQ_K2: begin
                    st_d.seq = SQ_IDLE;
                    case (kind)
                        CY_PROG: begin
                            st_d.prot  = 1'b1;
                            st_d.grant = 1'b1;
                        end
                        CY_EXT:    st_d.seq = SQ_X0;
                        CY_ID_IN:  st_d.id  = 1'b1;
                        CY_ID_OUT: st_d.id  = 1'b0;
                        default: ;
                    endcase
                end
                SQ_X0: st_d.seq = (kind == CY_KEY1) ? SQ_X1 : SQ_IDLE;
                SQ_X1: st_d.seq = (kind == CY_KEY2) ? SQ_X2 : SQ_IDLE;
                SQ_X2: begin
                    st_d.seq = SQ_IDLE;
                    case (kind)
                        CY_UNPROT: st_d.prot  = 1'b0;
                        CY_ERASE:  st_d.erase = 1'b1;
                        CY_ID_ALT: st_d.id    = 1'b1;
                        default: ;
                    endcase
                end
                default: st_d.seq = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    assign load_grant  = st_q.grant;
    assign prot_on     = st_q.prot;
    assign erase_start = st_q.erase;
    assign id_mode     = st_q.id;
    assign lockout     = lock_busy;

    // R12: nothing changes while the penalty runs
    p_lock_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> ($stable(prot_on) && $stable(id_mode) && !load_grant));

    // R12: only a protected part ever enters lockout
    p_lock_needs_prot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lockout) |-> prot_on);

    // R6: erase request is a single-cycle pulse
    p_erase_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);

    // R4: window holds until the page logic closes it
    p_grant_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_grant && !load_done) |=> load_grant);

    // R4: page data never alters the mode flags
    p_grant_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_grant |=> ($stable(prot_on) && $stable(id_mode)));

    // R3: protection only rises as the result of a bus write
    p_prot_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> ($past(wr_valid) && load_grant));
endmodule

// File: tb/unlock_cmd_decoder_tb.sv
module unlock_cmd_decoder_tb_top;
    localparam int LOCKN = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        load_done = 1'b0;
    logic [15:0] rd_addr = '0;
    logic        load_grant, prot_on, erase_start, lockout, id_mode;
    logic [7:0]  id_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    unlock_cmd_decoder #(.ADDR_W(16), .DATA_W(8), .LOCK_CYCLES(LOCKN)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .load_done(load_done), .rd_addr(rd_addr),
        .load_grant(load_grant), .prot_on(prot_on), .erase_start(erase_start),
        .lockout(lockout), .id_mode(id_mode), .id_rdata(id_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic done_pulse();
        load_done = 1'b1;
        @(negedge clk);
        load_done = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic seq3(input logic [7:0] d);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, d);
    endtask

    task automatic seq6(input logic [7:0] d);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, d);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        int n;
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 flags", {27'd0, prot_on, id_mode, load_grant, erase_start, lockout}, 32'd0);
        chk("R1 id_rdata", id_rdata, 8'h00);

        // R3 R7 R8 R10: every value in the third position
        for (int v = 0; v < 256; v++) begin
            do_reset();
            seq3(v[7:0]);
            chk($sformatf("R3/R7/R10 third=%02h", v),
                {29'd0, prot_on, load_grant, id_mode},
                {29'd0, v == 8'hA0, v == 8'hA0, v == 8'h90});
        end

        // R5 R6 R9: every value in the sixth position, protection on
        for (int v = 0; v < 256; v++) begin
            do_reset();
            seq3(8'hA0);
            done_pulse();
            seq6(v[7:0]);
            chk($sformatf("R5/R6/R9 sixth=%02h", v),
                {28'd0, erase_start, prot_on, id_mode, lockout},
                {28'd0, v == 8'h10, v != 8'h20, v == 8'h60, 1'b0});
            @(negedge clk);
            chk("R6 pulse ends", erase_start, 1'b0);
        end

        // R2: bit 15 ignored; low-bit mismatch aborts
        do_reset();
        wr(16'hD555, 8'hAA); wr(16'hAAAA, 8'h55); wr(16'hD555, 8'hA0);
        chk("R2 bit15 ignored", prot_on, 1'b1);
        do_reset();
        wr(16'h5555, 8'hAA); wr(16'h2AAB, 8'h55); wr(16'h5555, 8'h90);
        chk("R2 addr mismatch id", id_mode, 1'b0);
        chk("R2 addr mismatch plain", load_grant, 1'b1);

        // R10: wrong data in step two, dropped, then plain write
        do_reset();
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h12);
        chk("R10 abort no grant", load_grant, 1'b0);
        wr(16'h5555, 8'hA0);
        chk("R10 abort prot", prot_on, 1'b0);
        chk("R10 abort plain grant", load_grant, 1'b1);

        // R11: plain write opens window when unprotected
        do_reset();
        wr(16'h1234, 8'h5A);
        chk("R11 grant", load_grant, 1'b1);
        chk("R11 no lockout", lockout, 1'b0);

        // R4: window data not decoded, closes on load_done
        do_reset();
        seq3(8'hA0);
        seq3(8'h90);
        chk("R4 id unchanged", id_mode, 1'b0);
        chk("R4 grant held", load_grant, 1'b1);
        done_pulse();
        chk("R4 grant closed", load_grant, 1'b0);

        // R12: rejected write, lockout length, writes ignored
        wr(16'h0042, 8'h77);
        chk("R12 no grant", load_grant, 1'b0);
        chk("R12 lockout on", lockout, 1'b1);
        seq3(8'h90);
        chk("R12 ignored id", id_mode, 1'b0);
        n = 3;
        while (lockout && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk("R12 lockout length", n, LOCKN);
        seq3(8'h90);
        chk("R12 accepted after", id_mode, 1'b1);

        // R7: identification reads
        rd_addr = 16'h0000; #1 chk("R7 addr0", id_rdata, 8'hBF);
        rd_addr = 16'h0001; #1 chk("R7 addr1", id_rdata, 8'h5D);
        rd_addr = 16'h8001; #1 chk("R7 addr8001", id_rdata, 8'h5D);
        rd_addr = 16'h0002; #1 chk("R7 addr2", id_rdata, 8'h00);
        rd_addr = 16'h7FFF; #1 chk("R7 addr7fff", id_rdata, 8'h00);
        @(negedge clk);

        // R8: exit identification mode
        seq3(8'hF0);
        chk("R8 exit", id_mode, 1'b0);
        rd_addr = 16'h0000; #1 chk("R7 outside id", id_rdata, 8'h00);
        @(negedge clk);
        chk("R8 prot kept", prot_on, 1'b1);

        summary();
    end
endmodule